// File: doc/BRIEF.md
# Mailbox Word FIFO with Watermark Events

This block carries 32-bit words from a sending processor to a receiving processor through a 32-deep queue. Both sides reach it through one shared register port. The sender stores a word by writing the push offset. The receiver removes the oldest word by reading the pop offset. A status register shows the fill state and two sticky error flags. The fill threshold is programmable, and crossing it in either direction is reported as its own event.

Seven event bits sit in one shared interrupt status register, and each bit is cleared by writing 1. Each side has its own enable mask, and each side's interrupt line is the OR of the pending events it has enabled. A self-clearing reset control empties the queue and clears the sticky flags. It leaves the watermark, the pending events and the enables as they were.

The register port never applies back-pressure. Every access presented with `bus_valid` is taken in the cycle it appears. Read data comes back one cycle later, qualified by `bus_rvalid`. A sender that pushes into a full queue loses that word and is told so through the overflow flag. Flow control is therefore the job of software, using the watermark and empty events.

Top module: `mbx_wfifo`

## Requirements
- R1: After reset the status register (0xB4) reads 0x4 (only the empty flag set), the watermark register (0xB8) reads 32, the interrupt status (0xC8) and both enable registers read 0, and both interrupt outputs are low.
- R2: Words written to 0xAC are returned by reads of 0xB0 in the order they were written. A read access in cycle k puts its data on `bus_rdata` with `bus_rvalid` high in cycle k+1; a write access produces no `bus_rvalid`.
- R3: A write to 0xAC while 32 words are held is dropped. The level stays 32, status bit 4 (overflow) is set and stays set until a queue reset, and interrupt bit 6 is raised.
- R4: A read of 0xB0 while the queue is empty returns 0 and leaves the level at 0. It sets status bit 3 (underflow), which stays set until a queue reset, and raises interrupt bit 7.
- R5: Status bit 0 is 1 exactly when the level is at or above the watermark (the low 6 bits of the last value written to 0xB8). Bit 1 is 1 when the level is 32, and bit 2 is 1 when the level is 0.
- R6: Interrupt bit 4 is raised in the cycle status bit 0 goes from 0 to 1, and interrupt bit 5 in the cycle it goes from 1 to 0. This holds whether the change comes from a push, a pop or a watermark write.
- R7: Interrupt bits 2 (full), 3 (empty) and 8 (not empty) are raised only on entry into their condition. Once cleared, they are not raised again while that condition persists.
- R8: Writing 0xC4 clears each interrupt status bit whose data bit is 1. Bits written as 0 are left unchanged.
- R9: Writing 0xCC with data bit 0 set empties the queue and clears both sticky flags. It raises no event and leaves the interrupt status and the watermark unchanged. 0xCC always reads 0.
- R10: `irq_sender` is the OR of interrupt status ANDed with the sender mask at 0xBC. `irq_receiver` is the same using the receiver mask at 0xC0. Only mask bits 8 down to 2 are writable; the other bits read 0.
- R11: Reads of unmapped offsets or of 0xAC return 0. Writes to unmapped offsets, 0xB0, 0xB4 or 0xC8 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access presented this cycle; always accepted |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Pulses one cycle after each read access |
| irq_sender | output | 1 | Sender interrupt: pending events under the sender mask |
| irq_receiver | output | 1 | Receiver interrupt: pending events under the receiver mask |

## Verification
The bench pushes the queue past 32 words and pops it past empty. A design that stored the extra word would hand back a word that was never legally accepted. A design that advanced the read pointer on an empty pop would return stale data instead of zero. The watermark is also moved underneath a constant level, so a design that detects crossings only on push or pop misses the events that come from a watermark write alone. Full and not-empty events are cleared while their condition still holds, which exposes a level-triggered design that keeps re-raising them. The queue reset is issued with events pending, to catch a design that clears the interrupt status or invents an empty event.

// File: rtl/mbx_wfifo_pkg.sv
package mbx_wfifo_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_PUSH  = 8'hAC;
  localparam logic [ADDR_W-1:0] OFS_POP   = 8'hB0;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'hB4;
  localparam logic [ADDR_W-1:0] OFS_WMARK = 8'hB8;
  localparam logic [ADDR_W-1:0] OFS_SEN   = 8'hBC;
  localparam logic [ADDR_W-1:0] OFS_REN   = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 8'hC4;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'hC8;
  localparam logic [ADDR_W-1:0] OFS_FRST  = 8'hCC;

  // status register bit positions
  localparam int unsigned ST_WM    = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_EMPTY = 2;
  localparam int unsigned ST_UDF   = 3;
  localparam int unsigned ST_OVF   = 4;
  localparam int unsigned ST_W     = 5;

  // event bit positions in the shared interrupt registers
  localparam int unsigned EV_FULL  = 2;
  localparam int unsigned EV_EMPTY = 3;
  localparam int unsigned EV_WMUP  = 4;
  localparam int unsigned EV_WMDN  = 5;
  localparam int unsigned EV_OVF   = 6;
  localparam int unsigned EV_UDF   = 7;
  localparam int unsigned EV_NEMP  = 8;
  localparam int unsigned EV_W     = 9;
  localparam logic [EV_W-1:0] EV_MASK = 9'h1FC;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_PUSH, ACC_POP, ACC_STAT, ACC_WMARK,
    ACC_SEN, ACC_REN, ACC_ICLR, ACC_ISTAT, ACC_FRST
  } acc_e;

  function automatic acc_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PUSH:  return ACC_PUSH;
      OFS_POP:   return ACC_POP;
      OFS_STAT:  return ACC_STAT;
      OFS_WMARK: return ACC_WMARK;
      OFS_SEN:   return ACC_SEN;
      OFS_REN:   return ACC_REN;
      OFS_ICLR:  return ACC_ICLR;
      OFS_ISTAT: return ACC_ISTAT;
      OFS_FRST:  return ACC_FRST;
      default:   return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mbx_wfifo_store.sv
module mbx_wfifo_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,      // caller guarantees not full
  input  logic             pop,       // caller guarantees not empty
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nx
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    level_nx = level_q;
    if (flush)             level_nx = '0;
    else if (push && !pop) level_nx = level_q + 1'b1;
    else if (pop && !push) level_nx = level_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      level_q <= level_nx;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= bump(wr_ptr);
        if (pop)  rd_ptr <= bump(rd_ptr);
      end
    end
  end

  assign head  = mem[rd_ptr];
  assign level = level_q;
endmodule

// File: rtl/mbx_wfifo_events.sv
module mbx_wfifo_events
  import mbx_wfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_q,
  input  logic [LVL_W-1:0] level_nx,
  input  logic             wm_now,
  input  logic             wm_nxt,
  input  logic             ovf_hit,
  input  logic             udf_hit,
  input  logic             flush,
  input  logic             clr,
  input  logic [EV_W-1:0]  clr_mask,
  output logic [EV_W-1:0]  istat
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [EV_W-1:0] raise;

  // transitions are judged between the current and the next state,
  // so an event lands on the same edge as the change that causes it
  always_comb begin
    raise = '0;
    if (!flush) begin
      raise[EV_FULL]  = (level_nx == FULL_LVL) && (level_q != FULL_LVL);
      raise[EV_EMPTY] = (level_nx == '0) && (level_q != '0);
      raise[EV_NEMP]  = (level_nx != '0) && (level_q == '0);
      raise[EV_WMUP]  = wm_nxt && !wm_now;
      raise[EV_WMDN]  = !wm_nxt && wm_now;
      raise[EV_OVF]   = ovf_hit;
      raise[EV_UDF]   = udf_hit;
    end
  end

  for (genvar b = 0; b < EV_W; b++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) istat[b] <= 1'b0;
      else        istat[b] <= EV_MASK[b] & (raise[b] | (istat[b] & ~(clr & clr_mask[b])));
    end
  end
endmodule

// File: rtl/mbx_wfifo.sv
module mbx_wfifo
  import mbx_wfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_sender,
  output logic              irq_receiver
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  acc_e acc;
  logic wr_req, rd_req;
  logic push_req, pop_req, flush, wmark_we, iclr_we;
  logic full, empty, do_push, do_pop, ovf_hit, udf_hit;
  logic [LVL_W-1:0] level_q, level_nx, wmark_q, wmark_nx;
  logic wm_now, wm_nxt;
  logic ovf_q, udf_q;
  logic [EV_W-1:0] sen_q, ren_q, istat;
  logic [DATA_W-1:0] head, rd_nx;
  logic [ST_W-1:0] stat;

  assign acc      = decode_ofs(bus_addr);
  assign wr_req   = bus_valid && bus_write;
  assign rd_req   = bus_valid && !bus_write;
  assign push_req = wr_req && (acc == ACC_PUSH);
  assign pop_req  = rd_req && (acc == ACC_POP);
  assign flush    = wr_req && (acc == ACC_FRST) && bus_wdata[0];
  assign wmark_we = wr_req && (acc == ACC_WMARK);
  assign iclr_we  = wr_req && (acc == ACC_ICLR);

  assign full    = (level_q == FULL_LVL);
  assign empty   = (level_q == '0);
  assign do_push = push_req && !full;
  assign ovf_hit = push_req && full;
  assign do_pop  = pop_req && !empty;
  assign udf_hit = pop_req && empty;

  mbx_wfifo_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .flush(flush),
    .wdata(bus_wdata), .head(head), .level(level_q), .level_nx(level_nx)
  );

  assign wmark_nx = wmark_we ? bus_wdata[LVL_W-1:0] : wmark_q;
  assign wm_now   = (level_q >= wmark_q);
  assign wm_nxt   = (level_nx >= wmark_nx);

  mbx_wfifo_events #(.DEPTH(DEPTH)) u_events (
    .clk(clk), .rst_n(rst_n), .level_q(level_q), .level_nx(level_nx),
    .wm_now(wm_now), .wm_nxt(wm_nxt), .ovf_hit(ovf_hit), .udf_hit(udf_hit),
    .flush(flush), .clr(iclr_we), .clr_mask(bus_wdata[EV_W-1:0]), .istat(istat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmark_q <= FULL_LVL;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      sen_q   <= '0;
      ren_q   <= '0;
    end else begin
      wmark_q <= wmark_nx;
      if (flush) begin
        ovf_q <= 1'b0;
        udf_q <= 1'b0;
      end else begin
        if (ovf_hit) ovf_q <= 1'b1;
        if (udf_hit) udf_q <= 1'b1;
      end
      if (wr_req && acc == ACC_SEN) sen_q <= bus_wdata[EV_W-1:0] & EV_MASK;
      if (wr_req && acc == ACC_REN) ren_q <= bus_wdata[EV_W-1:0] & EV_MASK;
    end
  end

  always_comb begin
    stat = '0;
    stat[ST_WM]    = wm_now;
    stat[ST_FULL]  = full;
    stat[ST_EMPTY] = empty;
    stat[ST_UDF]   = udf_q;
    stat[ST_OVF]   = ovf_q;
  end

  always_comb begin
    case (acc)
      ACC_POP:   rd_nx = empty ? '0 : head;
      ACC_STAT:  rd_nx = DATA_W'(stat);
      ACC_WMARK: rd_nx = DATA_W'(wmark_q);
      ACC_SEN:   rd_nx = DATA_W'(sen_q);
      ACC_REN:   rd_nx = DATA_W'(ren_q);
      ACC_ISTAT: rd_nx = DATA_W'(istat);
      default:   rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_nx;
    end
  end

  assign irq_sender   = |(istat & sen_q);
  assign irq_receiver = |(istat & ren_q);
endmodule

// File: rtl/mbx_wfifo_chk.sv
module mbx_wfifo_chk
  import mbx_wfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [LVL_W-1:0]  level,
  input logic              ovf,
  input logic              udf,
  input logic              flush
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_no_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_PUSH && level == FULL_LVL)
      |=> (level == FULL_LVL && ovf));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> ovf);

  assert_zero_on_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_POP && level == '0)
      |=> (bus_rdata == '0 && udf && level == '0));

  assert_udf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (udf && !flush) |=> udf);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !ovf && !udf));
endmodule

bind mbx_wfifo mbx_wfifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .level(level_q), .ovf(ovf_q), .udf(udf_q), .flush(flush)
);

// File: tb/mbx_wfifo_test.sv
`timescale 1ns/1ps
module mbx_wfifo_test;
  import mbx_wfifo_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq_sender, irq_receiver;

  always #2 clk = ~clk;

  mbx_wfifo uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_sender(irq_sender), .irq_receiver(irq_receiver)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  int unsigned q[$];
  int m_wm = 32;
  bit m_ovf = 0, m_udf = 0;
  logic [8:0] m_ist = '0, m_sen = '0, m_ren = '0;

  function automatic bit reached(int lvl, int wm);
    return lvl >= wm;
  endfunction

  function automatic logic [31:0] exp_stat();
    int l = q.size();
    return {27'd0, m_ovf, m_udf, (l == 0), (l == 32), reached(l, m_wm)};
  endfunction

  function automatic void model_events(int lb, int la, int wb, int wa);
    if (la == 32 && lb != 32) m_ist[2] = 1'b1;
    if (la == 0 && lb != 0)   m_ist[3] = 1'b1;
    if (la != 0 && lb == 0)   m_ist[8] = 1'b1;
    if (reached(la, wa) && !reached(lb, wb)) m_ist[4] = 1'b1;
    if (!reached(la, wa) && reached(lb, wb)) m_ist[5] = 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic rv);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rd = bus_rdata; rv = bus_rvalid;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic chk_irq(input string req);
    chk({req, " irq_sender"},   {31'd0, irq_sender},   {31'd0, |(m_ist & m_sen)});
    chk({req, " irq_receiver"}, {31'd0, irq_receiver}, {31'd0, |(m_ist & m_ren)});
  endtask

  task automatic rd_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic rv;
    bus(1'b0, a, 32'd0, rd, rv);
    chk({req, " rvalid"}, {31'd0, rv}, 32'd1);
    chk(req, rd, exp);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    bus(1'b1, a, d, rd, rv);
  endtask

  task automatic do_push(input logic [31:0] d);
    int lb = q.size();
    if (lb == 32) begin m_ovf = 1; m_ist[6] = 1'b1; end
    else q.push_back(d);
    model_events(lb, q.size(), m_wm, m_wm);
    wr_reg(OFS_PUSH, d);
    chk_irq("R10 push");
  endtask

  task automatic do_pop(input string req);
    int lb = q.size();
    logic [31:0] e;
    if (lb == 0) begin e = 0; m_udf = 1; m_ist[7] = 1'b1; end
    else e = q.pop_front();
    model_events(lb, q.size(), m_wm, m_wm);
    rd_reg(req, OFS_POP, e);
    chk_irq("R10 pop");
  endtask

  task automatic set_wm(input logic [31:0] v);
    int wb = m_wm;
    m_wm = int'(v & 32'h3F);
    model_events(q.size(), q.size(), wb, m_wm);
    wr_reg(OFS_WMARK, v);
    chk_irq("R10 wmark");
  endtask

  task automatic clr_ev(input logic [31:0] m);
    m_ist &= ~(m[8:0] & 9'h1FC);
    wr_reg(OFS_ICLR, m);
    chk_irq("R8 clear");
  endtask

  task automatic do_flush();
    q.delete(); m_ovf = 0; m_udf = 0;
    wr_reg(OFS_FRST, 32'h1);
    chk_irq("R9 flush");
  endtask

  task automatic set_en(input bit rcv, input logic [31:0] v);
    if (rcv) m_ren = v[8:0] & 9'h1FC; else m_sen = v[8:0] & 9'h1FC;
    wr_reg(rcv ? OFS_REN : OFS_SEN, v);
    chk_irq("R10 enable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_sender", {31'd0, irq_sender}, 32'd0);
    chk("R1 irq_receiver", {31'd0, irq_receiver}, 32'd0);
    rd_reg("R1 status", OFS_STAT, 32'h4);
    rd_reg("R1 watermark", OFS_WMARK, 32'd32);
    rd_reg("R1 istat", OFS_ISTAT, 32'd0);
    rd_reg("R1 sender mask", OFS_SEN, 32'd0);
    rd_reg("R1 receiver mask", OFS_REN, 32'd0);

    // R2 ordering, R7 entry events
    for (int i = 0; i < 5; i++) do_push(32'hA500_0000 + i);
    for (int i = 0; i < 5; i++) do_pop("R2 order");
    rd_reg("R7 empty+notempty events", OFS_ISTAT, 32'h108);
    clr_ev(32'h008);
    rd_reg("R8 partial clear", OFS_ISTAT, 32'h100);
    clr_ev(32'h1FF);
    rd_reg("R8 full clear", OFS_ISTAT, 32'h0);

    // R6 watermark crossings from push, pop and watermark write
    set_wm(3);
    for (int i = 0; i < 3; i++) do_push(32'h100 + i);
    rd_reg("R5 wm reached", OFS_STAT, exp_stat());
    rd_reg("R6 rising", OFS_ISTAT, {23'd0, m_ist});
    clr_ev(32'h1FF);
    do_pop("R2 pop");
    rd_reg("R6 falling", OFS_ISTAT, 32'h020);
    set_wm(1);
    rd_reg("R6 rising by wmark write", OFS_ISTAT, 32'h030);
    set_wm(40);
    rd_reg("R6 falling by wmark write", OFS_ISTAT, 32'h030);
    clr_ev(32'h1FF);

    // R3 overflow, R7 no re-raise while full
    set_wm(32);
    while (q.size() < 32) do_push($urandom());
    rd_reg("R5 full status", OFS_STAT, exp_stat());
    clr_ev(32'h1FF);
    do_push(32'hDEAD_BEEF);
    rd_reg("R3 overflow status", OFS_STAT, 32'h13);
    rd_reg("R7 no full re-raise, R3 ovf event", OFS_ISTAT, 32'h040);
    do_pop("R3 head kept");
    rd_reg("R3 overflow sticky", OFS_STAT, exp_stat());
    do_push(32'h1234_5678);
    rd_reg("R7 full re-entry", OFS_ISTAT, {23'd0, m_ist});

    // R10 interrupt masks
    set_en(1'b0, 32'hFFFF_FFFF);
    rd_reg("R10 sender mask bits", OFS_SEN, 32'h1FC);
    set_en(1'b0, 32'h040);
    set_en(1'b1, 32'h010);
    clr_ev(32'h1FF);
    set_en(1'b1, 32'h080);

    // R9 queue reset
    set_wm(5);
    do_flush();
    rd_reg("R9 status after reset", OFS_STAT, 32'h4);
    rd_reg("R9 istat unchanged", OFS_ISTAT, {23'd0, m_ist});
    rd_reg("R9 watermark kept", OFS_WMARK, 32'd5);
    rd_reg("R9 reads zero", OFS_FRST, 32'd0);

    // R4 underflow
    do_pop("R4 empty pop zero");
    rd_reg("R4 underflow status", OFS_STAT, 32'h0C);
    do_pop("R4 second empty pop");
    rd_reg("R4 underflow event", OFS_ISTAT, {23'd0, m_ist});

    // R11 ignored accesses
    do_push(32'h77);
    wr_reg(OFS_STAT, 32'hFFFF_FFFF);
    wr_reg(OFS_ISTAT, 32'hFFFF_FFFF);
    wr_reg(OFS_POP, 32'hFFFF_FFFF);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    chk_irq("R11 ignored writes");
    rd_reg("R11 push offset reads 0", OFS_PUSH, 32'd0);
    rd_reg("R11 unmapped reads 0", 8'h04, 32'd0);
    rd_reg("R11 status intact", OFS_STAT, exp_stat());
    rd_reg("R11 istat intact", OFS_ISTAT, {23'd0, m_ist});
    do_pop("R11 data intact");

    // constrained random
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(99);
      if (r < 38)      do_push($urandom());
      else if (r < 70) do_pop("R2 random pop");
      else if (r < 76) rd_reg("R5 random status", OFS_STAT, exp_stat());
      else if (r < 82) rd_reg("R6 random istat", OFS_ISTAT, {23'd0, m_ist});
      else if (r < 87) set_wm($urandom_range(40));
      else if (r < 92) clr_ev($urandom());
      else if (r < 96) set_en(r[0], $urandom());
      else if (r < 98) rd_reg("R5 random watermark", OFS_WMARK, m_wm);
      else             do_flush();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule